// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block builds one deep FIFO from a row of smaller first-word-fall-through stages, each 9 bits wide by default. Stages talk to each other only through a pair of active-low ready flags. The output-ready flag of one stage acts as the write enable of the next, and the input-ready flag of the next acts as the read enable of the one before. There is no other glue logic. A word entering an empty chain moves down to the output with no read request. A slot freed at the output moves back up to the input in the same unprompted way. Each hop has a fixed cycle cost.

All stages share one clock, which also moves data between stages. Each stage holds a circular buffer and a separate output register. A small output state machine in each stage controls that register. Its states are `ST_EMPTY`, `ST_WAKE1`, `ST_WAKE2` and `ST_PRESENT`, with these transitions:
- EMPTY→WAKE1 when the buffer holds a word; the output register loads at this step.
- WAKE1→WAKE2 and WAKE2→PRESENT unconditionally.
- PRESENT→PRESENT on a read while the buffer still holds a word; the output register reloads.
- PRESENT→EMPTY on a read with the buffer empty.

The output-ready flag is low only in `ST_PRESENT`. The input-ready flag rises as soon as a stage becomes full. It falls two edges after a slot frees.

Top module: `fwft_chain`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_rdy_n` is 1 and `in_rdy_n` is 0.
- R2: Words leave `dout` in the order they were accepted, unaltered. A write is accepted at an edge where `wr_n`=0 and `in_rdy_n`=0. A read is accepted at an edge where `rd_n`=0 and `out_rdy_n`=0.
- R3: Starting empty, with no reads, exactly `N_STAGES*STAGE_DEPTH` writes are accepted, and `in_rdy_n` is then 1.
- R4: For a write accepted at edge w into an empty chain, `out_rdy_n` falls exactly at edge w+(N_STAGES-1)*4+3. This gives 7 for two stages and 11 for three.
- R5: Take a full chain that has settled. For a read accepted at edge r, `in_rdy_n` falls exactly at edge r+(N_STAGES-1)*3+2. This gives 5 for two stages and 8 for three.
- R6: From a settled full chain with `STAGE_DEPTH` of at least 8, reads on every cycle drain all `N_STAGES*STAGE_DEPTH` words with `out_rdy_n` low before every one of those edges.
- R7: A write presented while `in_rdy_n` is 1 is ignored. It stores nothing and leaves the stored words and their order intact.
- R8: A read presented while `out_rdy_n` is 1 is ignored. While `out_rdy_n` is 0 and no read is made, `out_rdy_n` stays 0 and `dout` holds its value.
- R9: After the last stored word is read, `out_rdy_n` is 1 following that edge. `out_rdy_n` is never 0 while the chain is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, also the inter-stage transfer clock |
| rst | input | 1 | Synchronous active-high reset, empties every stage |
| din | input | DATA_W | Write data into the first stage |
| wr_n | input | 1 | Active-low write request |
| in_rdy_n | output | 1 | Active-low: first stage can accept a word |
| dout | output | DATA_W | Head word of the last stage |
| rd_n | input | 1 | Active-low read request |
| out_rdy_n | output | 1 | Active-low: `dout` holds a valid word |

## Verification
The chain is tried with four input patterns. A single isolated word into an empty chain times the ripple-down path. A burst fill against a blocked output shows whether the capacity is the sum of the stages. A single read from a settled full chain times the bubble-up path. An unbroken read stream from full separates a design that streams from one that pays the ripple delay again per word. Writes against a full chain and reads against an empty one show whether blocked requests leak into storage. Latencies are measured on both a two-stage and a three-stage chain, so a wrong per-stage constant cannot hide behind a matching fixed offset.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;

    // Output-side state of one stage
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_WAKE1   = 2'd1,
        ST_WAKE2   = 2'd2,
        ST_PRESENT = 2'd3
    } out_state_t;

endpackage

// File: rtl/fwft_stage_mem.sv
module fwft_stage_mem #(
    parameter  int DATA_W = 9,
    parameter  int DEPTH  = 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_data = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/fwft_stage_ctrl.sv
module fwft_stage_ctrl
    import fwft_chain_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int OCC_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [CNT_W-1:0] mem_cnt,
    output logic             push,
    output logic             pop,
    output logic             or_n,
    output logic             ir_n
);

    out_state_t       st_q;
    out_state_t       st_d;
    logic             free_d1;
    logic             free_d2;
    logic             ir_q;
    logic             rd_ok;
    logic             mem_any;
    logic [OCC_W-1:0] occ_nxt;

    assign mem_any = (mem_cnt != '0);
    assign push    = !wr_n && !ir_q;
    assign rd_ok   = !rd_n && (st_q == ST_PRESENT);

    // Next-state and buffer pop decision
    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                if (mem_any) begin
                    st_d = ST_WAKE1;
                    pop  = 1'b1;
                end
            end
            ST_WAKE1: st_d = ST_WAKE2;
            ST_WAKE2: st_d = ST_PRESENT;
            ST_PRESENT: begin
                if (rd_ok) begin
                    if (mem_any) begin
                        pop = 1'b1;
                    end else begin
                        st_d = ST_EMPTY;
                    end
                end
            end
        endcase
    end

    // Stored words after this edge: buffer plus the output register
    assign occ_nxt = OCC_W'(mem_cnt) + OCC_W'(push) - OCC_W'(pop)
                   + OCC_W'(st_d != ST_EMPTY);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // Flag outputs: full asserts at once, a freed slot shows two edges later
    always_ff @(posedge clk) begin
        if (rst) begin
            free_d1 <= 1'b1;
            free_d2 <= 1'b1;
            ir_q    <= 1'b0;
        end else begin
            free_d1 <= (occ_nxt < OCC_W'(DEPTH));
            free_d2 <= free_d1;
            ir_q    <= !((occ_nxt < OCC_W'(DEPTH)) && free_d2);
        end
    end

    assign or_n = (st_q != ST_PRESENT);
    assign ir_n = ir_q;

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
    parameter  int DATA_W = 9,
    parameter  int DEPTH  = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    output logic              ir_n,
    output logic [DATA_W-1:0] dout,
    input  logic              rd_n,
    output logic              or_n
);

    logic              push;
    logic              pop;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] out_q;

    fwft_stage_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (din),
        .pop       (pop),
        .pop_data  (head),
        .count     (cnt)
    );

    fwft_stage_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .mem_cnt (cnt),
        .push    (push),
        .pop     (pop),
        .or_n    (or_n),
        .ir_n    (ir_n)
    );

    // Output holding register, loaded on every pop
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (pop) begin
            out_q <= head;
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
    parameter int DATA_W      = 9,
    parameter int N_STAGES    = 2,
    parameter int STAGE_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    output logic              in_rdy_n,
    output logic [DATA_W-1:0] dout,
    input  logic              rd_n,
    output logic              out_rdy_n
);

    logic [DATA_W-1:0] st_dout [N_STAGES];
    logic              st_or_n [N_STAGES];
    logic              st_ir_n [N_STAGES];

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        logic [DATA_W-1:0] s_din;
        logic              s_wr_n;
        logic              s_rd_n;

        if (k == 0) begin : g_head
            assign s_din  = din;
            assign s_wr_n = wr_n;
        end else begin : g_link_in
            assign s_din  = st_dout[k-1];
            assign s_wr_n = st_or_n[k-1];
        end

        if (k == N_STAGES - 1) begin : g_tail
            assign s_rd_n = rd_n;
        end else begin : g_link_out
            assign s_rd_n = st_ir_n[k+1];
        end

        fwft_stage #(.DATA_W(DATA_W), .DEPTH(STAGE_DEPTH)) u_stage (
            .clk  (clk),
            .rst  (rst),
            .din  (s_din),
            .wr_n (s_wr_n),
            .ir_n (st_ir_n[k]),
            .dout (st_dout[k]),
            .rd_n (s_rd_n),
            .or_n (st_or_n[k])
        );
    end

    assign in_rdy_n  = st_ir_n[0];
    assign dout      = st_dout[N_STAGES-1];
    assign out_rdy_n = st_or_n[N_STAGES-1];

endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
    parameter  int DATA_W      = 9,
    parameter  int N_STAGES    = 2,
    parameter  int STAGE_DEPTH = 8,
    localparam int CAP         = N_STAGES * STAGE_DEPTH,
    localparam int OCC_W       = $clog2(CAP + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              wr_n,
    input logic              in_rdy_n,
    input logic [DATA_W-1:0] dout,
    input logic              rd_n,
    input logic              out_rdy_n
);

    logic [OCC_W-1:0] occ;
    logic             acc_wr;
    logic             acc_rd;
    logic [DATA_W-1:0] din_seen;

    assign acc_wr   = !wr_n && !in_rdy_n;
    assign acc_rd   = !rd_n && !out_rdy_n;
    assign din_seen = din;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + OCC_W'(acc_wr) - OCC_W'(acc_rd);
        end
    end

    assert_reset_flags_R1: assert property (@(posedge clk)
        rst |=> (out_rdy_n && !in_rdy_n));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(CAP));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == OCC_W'(CAP)) |-> in_rdy_n);

    assert_hold_head_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_rdy_n && rd_n) |=> (!out_rdy_n && $stable(dout)));

    assert_empty_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> out_rdy_n);

    assert_valid_has_data_R9: assert property (@(posedge clk) disable iff (rst)
        !out_rdy_n |-> (occ != '0));

endmodule

bind fwft_chain fwft_chain_chk #(
    .DATA_W      (DATA_W),
    .N_STAGES    (N_STAGES),
    .STAGE_DEPTH (STAGE_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .wr_n      (wr_n),
    .in_rdy_n  (in_rdy_n),
    .dout      (dout),
    .rd_n      (rd_n),
    .out_rdy_n (out_rdy_n)
);

// File: tb/fwft_chain_tb.sv
module fwft_chain_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 9;
    localparam int SD         = 8;
    localparam int N2         = 2;
    localparam int N3         = 3;
    localparam int CAP2       = N2 * SD;
    localparam int CAP3       = N3 * SD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [W-1:0] din = '0;
    logic         wr_n = 1'b1;
    logic         in_rdy_n;
    logic [W-1:0] dout;
    logic         rd_n = 1'b1;
    logic         out_rdy_n;

    logic [W-1:0] din3 = '0;
    logic         wr3_n = 1'b1;
    logic         in3_n;
    logic [W-1:0] dout3;
    logic         rd3_n = 1'b1;
    logic         out3_n;

    fwft_chain #(.DATA_W(W), .N_STAGES(N2), .STAGE_DEPTH(SD)) u_dut (
        .clk(clk), .rst(rst), .din(din), .wr_n(wr_n), .in_rdy_n(in_rdy_n),
        .dout(dout), .rd_n(rd_n), .out_rdy_n(out_rdy_n)
    );

    fwft_chain #(.DATA_W(W), .N_STAGES(N3), .STAGE_DEPTH(SD)) u_dut3 (
        .clk(clk), .rst(rst), .din(din3), .wr_n(wr3_n), .in_rdy_n(in3_n),
        .dout(dout3), .rd_n(rd3_n), .out_rdy_n(out3_n)
    );

    int           n_tests = 0;
    int           n_fail  = 0;
    int           rd_seen = 0;
    int           wr_seen = 0;
    bit           done    = 1'b0;
    logic [W-1:0] sb_q[$];
    logic [W-1:0] next_val = 9'h010;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: present one word; record it only if the chain takes it
    task automatic drive_word(input logic [W-1:0] v);
        din  = v;
        wr_n = 1'b0;
        if (!in_rdy_n) begin
            sb_q.push_back(v);
            wr_seen++;
        end
    endtask

    // Monitor: compare every accepted read with the scoreboard head
    always @(negedge clk) begin
        #2;
        if (!rst && !rd_n && !out_rdy_n) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "read accepted with nothing stored", int'(dout), -1);
            end else begin
                logic [W-1:0] exp_v;
                exp_v = sb_q.pop_front();
                check(dout == exp_v, "R2", "read order", int'(dout), int'(exp_v));
            end
            rd_seen++;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        int acc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: flags after reset, both chains
        check(out_rdy_n == 1'b1, "R1", "out_rdy_n after reset", int'(out_rdy_n), 1);
        check(in_rdy_n == 1'b0, "R1", "in_rdy_n after reset", int'(in_rdy_n), 0);
        check(out3_n == 1'b1 && in3_n == 1'b0, "R1", "3-stage flags after reset",
              int'({out3_n, in3_n}), 2);

        // R8: reads on an empty chain are ignored
        rd_n = 1'b0;
        repeat (5) @(negedge clk);
        rd_n = 1'b1;
        check(out_rdy_n == 1'b1, "R8", "out_rdy_n after empty reads", int'(out_rdy_n), 1);
        check(rd_seen == 0, "R8", "reads accepted while empty", rd_seen, 0);

        // R4: ripple-down latency, two stages
        @(negedge clk);
        drive_word(9'h0A5);
        @(negedge clk);
        wr_n = 1'b1;
        check(out_rdy_n == 1'b1, "R4", "out_rdy_n right after write", int'(out_rdy_n), 1);
        lat = 0;
        while (out_rdy_n && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (N2 - 1) * 4 + 3, "R4", "two-stage ripple latency", lat, (N2 - 1) * 4 + 3);
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        check(out_rdy_n == 1'b1, "R9", "out_rdy_n after last word read", int'(out_rdy_n), 1);

        // R4: ripple-down latency, three stages
        din3  = 9'h13C;
        wr3_n = 1'b0;
        @(negedge clk);
        wr3_n = 1'b1;
        lat = 0;
        while (out3_n && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (N3 - 1) * 4 + 3, "R4", "three-stage ripple latency", lat, (N3 - 1) * 4 + 3);
        check(dout3 == 9'h13C, "R2", "three-stage word value", int'(dout3), 'h13C);
        rd3_n = 1'b0;
        @(negedge clk);
        rd3_n = 1'b1;
        check(out3_n == 1'b1, "R9", "three-stage out_rdy_n after read", int'(out3_n), 1);

        // R3: fill the two-stage chain with no reads
        acc = wr_seen;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!in_rdy_n) begin
                drive_word(next_val);
                next_val++;
            end else begin
                wr_n = 1'b1;
            end
        end
        @(negedge clk);
        wr_n = 1'b1;
        check(wr_seen - acc == CAP2, "R3", "writes accepted until full", wr_seen - acc, CAP2);
        check(in_rdy_n == 1'b1, "R3", "in_rdy_n when full", int'(in_rdy_n), 1);

        // R7: writes against a full chain are dropped
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(in_rdy_n == 1'b1, "R7", "in_rdy_n during blocked write", int'(in_rdy_n), 1);
            drive_word(9'h1AA);
        end
        @(negedge clk);
        wr_n = 1'b1;
        repeat (10) @(negedge clk);

        // R5: bubble-up latency, two stages
        rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        check(in_rdy_n == 1'b1, "R5", "in_rdy_n right after read", int'(in_rdy_n), 1);
        lat = 0;
        while (in_rdy_n && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (N2 - 1) * 3 + 2, "R5", "two-stage bubble latency", lat, (N2 - 1) * 3 + 2);

        // Refill the single free slot and let the chain settle
        drive_word(next_val);
        next_val++;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (20) @(negedge clk);
        check(in_rdy_n == 1'b1, "R3", "in_rdy_n after refill", int'(in_rdy_n), 1);

        // R6: unbroken read stream from full
        acc = 0;
        for (int i = 0; i < CAP2; i++) begin
            if (!out_rdy_n) acc++;
            rd_n = 1'b0;
            @(negedge clk);
        end
        rd_n = 1'b1;
        check(acc == CAP2, "R6", "cycles with out_rdy_n low during stream", acc, CAP2);
        check(out_rdy_n == 1'b1, "R9", "out_rdy_n after draining", int'(out_rdy_n), 1);
        check(sb_q.size() == 0, "R7", "words left in scoreboard", sb_q.size(), 0);
        check(rd_seen == wr_seen, "R2", "reads equal accepted writes", rd_seen, wr_seen);

        // R5: bubble-up latency, three stages
        acc = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (!in3_n) begin
                din3  = W'(i);
                wr3_n = 1'b0;
                acc++;
            end else begin
                wr3_n = 1'b1;
            end
        end
        @(negedge clk);
        wr3_n = 1'b1;
        check(acc == CAP3, "R3", "three-stage capacity", acc, CAP3);
        repeat (10) @(negedge clk);
        rd3_n = 1'b0;
        @(negedge clk);
        rd3_n = 1'b1;
        lat = 0;
        while (in3_n && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (N3 - 1) * 3 + 2, "R5", "three-stage bubble latency", lat, (N3 - 1) * 3 + 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule